// File: doc/BRIEF.md
# Supervisory Reset Pulse Stretcher

This block turns three reset causes into a single processor reset: a digitized supply-good flag, an active-low manual reset button input and a watchdog trigger pulse. Reset is held for as long as any cause is present. Once the last cause has gone, reset stays asserted for a further recovery period of `TREC_CYCLES` clock cycles. The default value corresponds to 200 ms at 100 MHz.

Every new cause returns the recovery timer to zero. A supply dip or a watchdog trigger that arrives during recovery therefore makes the full period start again. The manual input comes from outside the clock domain and passes through a two-flop synchronizer. All other inputs are already synchronous to `clk`. The reset is provided in two polarities: an active-low output and an active-high output that is its exact complement.

Top module: `sup_reset_stretch`

## Requirements
- R1: While `supply_ok_i` is 0 when sampled at a clock edge, `proc_rst_n_o` is 0 after that edge.
- R2: A 0 driven on `man_rst_n_i` before edge k forces `proc_rst_n_o` to 0 from edge k+2 onward. This is the two-flop synchronizer plus one cycle. Reset stays 0 for as long as the input is held at 0.
- R3: A `wdog_trig_i` pulse one cycle long gives exactly `TREC_CYCLES` cycles of `proc_rst_n_o` = 0, starting after the edge that samples it.
- R4: After the last edge that samples a cause, `proc_rst_n_o` returns to 1 exactly `TREC_CYCLES` edges later. It never returns earlier.
- R5: A `supply_ok_i` dip to 0 during recovery clears the timer, and the full recovery period is counted from the last edge at which the supply was low.
- R6: A watchdog trigger during recovery restarts the full recovery period from that trigger.
- R7: While `rst_n` is 0, `proc_rst_n_o` is 0. After `rst_n` goes high with no cause active, `proc_rst_n_o` returns to 1 `TREC_CYCLES` edges after the last edge at which `rst_n` was low.
- R8: `proc_rst_o` is always the exact complement of `proc_rst_n_o`.
- R9: When `man_rst_n_i` returns to 1 before edge k, `proc_rst_n_o` returns to 1 after edge k+1+`TREC_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the clock domain |
| supply_ok_i | input | 1 | Digitized supply-good flag, 1 = supply within tolerance |
| man_rst_n_i | input | 1 | Manual reset button, active low, asynchronous |
| wdog_trig_i | input | 1 | Watchdog trigger, active high, synchronous |
| proc_rst_n_o | output | 1 | Processor reset, active low |
| proc_rst_o | output | 1 | Processor reset, active high, complement of `proc_rst_n_o` |

## Verification
The recovery counter is the only state of any length in this block. A counter that skips or repeats a value moves the release edge of `proc_rst_n_o` earlier or later by that many cycles. This shows up at the very first release after power-on. A missed clear shows up within a few cycles after a supply dip or a watchdog retrigger in mid-recovery, because the output then releases earlier than one full period after the retrigger. A synchronizer with the wrong depth shifts both the assert edge and the release edge of a manual reset by one cycle.

// File: rtl/sup_reset_pkg.sv
// Package: shared types for the supervisory reset stretcher.
// Assumes: nothing beyond IEEE 1800-2017.
package sup_reset_pkg;

    // Decoded reset causes, all active high.
    typedef struct packed {
        logic supply_low;
        logic manual;
        logic wdog;
    } cause_t;

endpackage

// File: rtl/sup_sync_chain.sv
// Module: sup_sync_chain
// Brings an asynchronous level into the clk domain through a chain of
// STAGES flops. Assumes: the input changes slowly compared with clk, and
// RESET_VAL is the inactive level of the signal.
module sup_sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the level through the chain; reset loads the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sup_cause_merge.sv
// Module: sup_cause_merge
// Decodes the three reset sources into active-high cause flags and their OR.
// Assumes: all inputs are already synchronous to clk.
module sup_cause_merge
    import sup_reset_pkg::*;
(
    input  logic   supply_ok,
    input  logic   manual_n_sync,
    input  logic   wdog_trig,
    output cause_t causes,
    output logic   any_cause
);

    // Convert each source to its active-high cause flag.
    always_comb begin
        causes.supply_low = ~supply_ok;
        causes.manual     = ~manual_n_sync;
        causes.wdog       = wdog_trig;
    end

    // Any cause present holds the timer at zero.
    assign any_cause = |causes;

endmodule

// File: rtl/sup_recovery_timer.sv
// Module: sup_recovery_timer
// Holds the count at zero while a cause is present, then counts up to
// TREC_CYCLES and stops. The registered release flag is 1 only at the
// terminal count. Assumes: TREC_CYCLES >= 2.
module sup_recovery_timer #(
    parameter int TREC_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    output logic released_o
);

    localparam int CW = $clog2(TREC_CYCLES + 1);
    localparam logic [CW-1:0] TERM = CW'(TREC_CYCLES);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          rel_q;

    // Next count: clear on any cause, otherwise advance until the terminal value.
    always_comb begin
        if (cause_i)
            cnt_d = '0;
        else if (cnt_q != TERM)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    // Count and release registers; power-on reset acts like a fresh supply rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            rel_q <= (cnt_d == TERM);
        end
    end

    assign released_o = rel_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM); // R4

    AST_CAUSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> (cnt_q == '0 && !rel_q)); // R5

    AST_STEADY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_i && cnt_q != TERM) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4

    AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_q) |-> ($past(cnt_q) == TERM - 1'b1 && !$past(cause_i))); // R3

endmodule

// File: rtl/sup_reset_stretch.sv
// Module: sup_reset_stretch (top)
// Merges supply-good, manual reset and watchdog trigger into a processor
// reset. The reset is stretched for TREC_CYCLES after the last cause clears.
// Assumes: supply_ok_i and wdog_trig_i are synchronous to clk, and
// man_rst_n_i is asynchronous.
module sup_reset_stretch
    import sup_reset_pkg::*;
#(
    parameter int TREC_CYCLES = 20_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic man_rst_n_i,
    input  logic wdog_trig_i,
    output logic proc_rst_n_o,
    output logic proc_rst_o
);

    logic   man_n_sync;
    cause_t causes;
    logic   any_cause;
    logic   released;

    sup_sync_chain #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_man_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (man_rst_n_i),
        .sync_o  (man_n_sync)
    );

    sup_cause_merge u_merge (
        .supply_ok     (supply_ok_i),
        .manual_n_sync (man_n_sync),
        .wdog_trig     (wdog_trig_i),
        .causes        (causes),
        .any_cause     (any_cause)
    );

    sup_recovery_timer #(
        .TREC_CYCLES (TREC_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_i    (any_cause),
        .released_o (released)
    );

    // Drive both reset polarities from the single registered release flag.
    assign proc_rst_n_o = released;
    assign proc_rst_o   = ~released;

    AST_SUPPLY_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> !proc_rst_n_o); // R1

    AST_WDOG_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_trig_i |=> (!proc_rst_n_o && proc_rst_o)); // R6

    AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        causes.manual |=> !proc_rst_n_o); // R2

endmodule

// File: tb/sup_reset_stretch_tb.sv
// Scoreboard bench: a driver task applies one cycle of stimulus at the
// falling edge and queues the expected reset level. A monitor pops the
// queue after each rising edge and compares it with the outputs.
module sup_reset_stretch_tb;

    localparam int TREC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic man_n = 1'b1;
    logic wdog = 1'b0;
    logic proc_rst_n, proc_rst;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    logic  q_exp[$];
    string q_tag[$];

    always #5 clk = ~clk;

    sup_reset_stretch #(
        .TREC_CYCLES (TREC),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok_i  (supply_ok),
        .man_rst_n_i  (man_n),
        .wdog_trig_i  (wdog),
        .proc_rst_n_o (proc_rst_n),
        .proc_rst_o   (proc_rst)
    );

    // One stimulus cycle; exp_asrt is the reset state expected after the next edge.
    task automatic step(input logic sup, input logic mn, input logic wd,
                        input logic exp_asrt, input string tag);
        @(negedge clk);
        supply_ok = sup;
        man_n     = mn;
        wdog      = wd;
        q_exp.push_back(~exp_asrt);
        q_tag.push_back(tag);
    endtask

    // No cause for n cycles: released from the TREC-th cycle after the last cause.
    task automatic run_release(input string tag, input int n);
        for (int j = 1; j <= n; j++) begin
            step(1'b1, 1'b1, 1'b0, (j < TREC), tag);
        end
    endtask

    // Monitor: compare both outputs with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() != 0) begin
                logic  e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_tests++;
                if (proc_rst_n !== e) begin
                    n_fail++;
                    $display("FAIL %s: proc_rst_n_o=%b expected %b at %0t", t, proc_rst_n, e, $time);
                end
                n_tests++;
                if (proc_rst !== ~e) begin
                    n_fail++;
                    $display("FAIL R8: proc_rst_o=%b expected %b at %0t", proc_rst, ~e, $time);
                end
            end
        end
    end

    // Driver: the scenarios.
    initial begin
        // R7: held in reset while rst_n low, then one full recovery period.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R7");
        @(negedge clk);
        rst_n = 1'b1;
        q_exp.push_back(1'b0);
        q_tag.push_back("R7");
        for (int j = 2; j <= TREC + 2; j++) step(1'b1, 1'b1, 1'b0, (j < TREC), "R7");

        // R1: supply low holds reset; R4: release TREC edges after the last low.
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R1");
        run_release("R4", TREC + 2);

        // R3: single-cycle watchdog trigger.
        step(1'b1, 1'b1, 1'b1, 1'b1, "R3");
        run_release("R3", TREC + 2);

        // R2: manual reset, two synchronizer cycles, then held.
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R2");
        // R9: release of the manual input, seen two cycles later.
        step(1'b1, 1'b1, 1'b0, 1'b1, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R9");
        run_release("R9", TREC + 2);

        // R5: supply dip in mid-recovery restarts the full period.
        step(1'b0, 1'b1, 1'b0, 1'b1, "R5");
        for (int j = 1; j <= 4; j++) step(1'b1, 1'b1, 1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R5");
        run_release("R5", TREC + 2);

        // R6: watchdog retrigger in mid-recovery restarts the full period.
        step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
        for (int j = 1; j <= TREC - 2; j++) step(1'b1, 1'b1, 1'b0, 1'b1, "R6");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
        run_release("R6", TREC + 2);

        while (q_exp.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule